// File: doc/BRIEF.md
# Fan Failure Supervisor With Timed Restart

This block watches a PWM-driven fan through a stream of 8-bit speed readings. Each reading is a count from a tach measurement front-end. The count grows as the fan slows and saturates at 255 when the fan has stopped. Every accepted reading is compared against a programmable ceiling. A reading above the ceiling is a failure.

Each failure does three things. It latches a sticky status flag, which drives the interrupt line. It forces the drive pin fully on for a fixed spin-up window to kick the fan back into motion. It advances a count of consecutive failures. After five failures in a row, an active-low fault pin is pulled low. Any passing reading clears the count and releases the pin. Failures after the fault still interrupt and still restart the fan. The pin polarity of the drive output can be chosen to suit the switching transistor.

Readings arrive on a valid/ready stream. `meas_ready_o` is tied high, so the block never applies back-pressure, and each cycle with `meas_valid_i` high consumes exactly one reading. The duty waveform, the tach front-end and the host bus are outside the block. A small synchronous register port gives the host access to configuration, the ceiling, status and the last reading.

Top module: `fan_guard`

## Requirements
- R1: Config bit 3 (invert) picks the pin polarity. With the bit set, `pwm_o` equals the internal drive, so full-on drives the pin high. With the bit clear, `pwm_o` is the complement of the drive. The drive is `pwm_duty_i` OR an active spin-up.
- R2: Config bit 4 (fault enable) resets to 1. While it is 0, `fan_fault_no` stays high whatever the failure count.
- R3: A reading is a failure only when it is strictly greater than the ceiling register. A reading equal to the ceiling passes.
- R4: Every failure sets status bit 1 one cycle after acceptance, and `irq_o` follows that bit. A host read of address 2 clears the bit after that cycle, unless a failure is accepted in the same cycle, in which case the bit stays set.
- R5: After a failure, the drive is forced on for SPIN_SEC*TICKS_PER_SEC pulses of `tick_i`. A new failure during the window reloads the full window.
- R6: `fan_fault_no` goes low (when enabled) the cycle after the fifth consecutive failure is accepted. The count saturates at five.
- R7: A passing reading resets the consecutive count to zero, so `fan_fault_no` is high on the next cycle.
- R8: Failures after the fault is raised still set the status bit and still reload the spin-up window.
- R9: Register map: address 0 is config, holding only bits 3 and 4 (reset 0x10; other bits read 0). Address 1 is the ceiling (reset 0xFE). Address 2 is status (bit 1 only). Address 3 is the last accepted reading (reset 0). Writes to addresses 2 and 3 are ignored. `reg_rdata_o` reflects `reg_addr_i` combinationally.
- R10: `meas_ready_o` is always high, and each cycle with `meas_valid_i` high counts as exactly one measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled time tick for the spin-up window |
| pwm_duty_i | input | 1 | Commanded duty waveform, high = drive on |
| meas_valid_i | input | 1 | Speed reading valid |
| meas_ready_o | output | 1 | Reading accepted (always high) |
| meas_speed_i | input | 8 | Speed count, 0xFF for a stalled fan |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status at address 2) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Interrupt, high while the status flag is set |
| fan_fault_no | output | 1 | Catastrophic fan fault, active low |
| pwm_o | output | 1 | Drive pin after spin-up override and polarity |

## Verification
Status, interrupt, fault pin and spin-up state all change one cycle after the accepting edge. Read data and `pwm_o` follow their inputs within the same cycle. The bench drives inputs just after a rising edge and compares every output at the following falling edge. Its behavioural model updates on the same rising edge, so each comparison sees exactly the state produced by the previous acceptance. Directed checks wait for the falling edge after the stimulus cycle and so observe the registered results at the cycle they are due.

// File: rtl/fan_guard_pkg.sv
package fan_guard_pkg;

  typedef enum logic [1:0] {
    ADDR_CFG    = 2'd0,
    ADDR_LIMIT  = 2'd1,
    ADDR_STATUS = 2'd2,
    ADDR_SPEED  = 2'd3
  } reg_addr_e;

  localparam int CFG_INV_BIT   = 3;
  localparam int CFG_FEN_BIT   = 4;
  localparam int STAT_FAIL_BIT = 1;

  typedef struct packed {
    logic fault_en;
    logic invert;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{fault_en: 1'b1, invert: 1'b0};

endpackage

// File: rtl/fan_guard_regs.sv
module fan_guard_regs
  import fan_guard_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] LIMIT_RESET = 8'hFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          meas_take_i,
  input  logic [DW-1:0] meas_speed_i,
  input  logic          fail_evt_i,
  output cfg_t          cfg_o,
  output logic [DW-1:0] limit_o,
  output logic          irq_o
);

  cfg_t          cfg_q;
  logic [DW-1:0] limit_q;
  logic [DW-1:0] last_q;
  logic          stat_q;
  reg_addr_e     addr;

  assign addr = reg_addr_e'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_RESET;
      limit_q <= LIMIT_RESET;
    end else if (reg_wr_i) begin
      if (addr == ADDR_CFG) begin
        cfg_q.invert   <= reg_wdata_i[CFG_INV_BIT];
        cfg_q.fault_en <= reg_wdata_i[CFG_FEN_BIT];
      end else if (addr == ADDR_LIMIT) begin
        limit_q <= reg_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else if (meas_take_i) last_q <= meas_speed_i;
  end

  // set has priority over read-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else if (fail_evt_i) stat_q <= 1'b1;
    else if (reg_rd_i && addr == ADDR_STATUS) stat_q <= 1'b0;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      ADDR_CFG: begin
        reg_rdata_o[CFG_INV_BIT] = cfg_q.invert;
        reg_rdata_o[CFG_FEN_BIT] = cfg_q.fault_en;
      end
      ADDR_LIMIT:  reg_rdata_o = limit_q;
      ADDR_STATUS: reg_rdata_o[STAT_FAIL_BIT] = stat_q;
      ADDR_SPEED:  reg_rdata_o = last_q;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign limit_o = limit_q;
  assign irq_o   = stat_q;

endmodule

// File: rtl/fan_guard_judge.sv
module fan_guard_judge #(
  parameter int DW         = 8,
  parameter int FAIL_LIMIT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [DW-1:0] speed_i,
  input  logic [DW-1:0] limit_i,
  output logic          fail_evt_o,
  output logic          fault_o
);

  localparam int CW = $clog2(FAIL_LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(FAIL_LIMIT);

  logic [CW-1:0] cnt_q;
  logic          over;

  assign over       = speed_i > limit_i;
  assign fail_evt_o = take_i && over;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (take_i) begin
      if (!over)             cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fault_o = (cnt_q == CMAX);

endmodule

// File: rtl/fan_guard_spinup.sv
module fan_guard_spinup #(
  parameter int TICKS_PER_SEC = 4,
  parameter int SPIN_SEC      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic tick_i,
  output logic spin_o
);

  localparam int SPIN_TICKS = TICKS_PER_SEC * SPIN_SEC;
  localparam int SW = $clog2(SPIN_TICKS + 1);
  localparam logic [SW-1:0] LOAD = SW'(SPIN_TICKS);

  logic [SW-1:0] left_q;

  // a fresh failure reloads the whole window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else if (kick_i) left_q <= LOAD;
    else if (tick_i && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign spin_o = (left_q != '0);

endmodule

// File: rtl/fan_guard.sv
module fan_guard
  import fan_guard_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4,
  parameter int SPIN_SEC      = 2,
  parameter int FAIL_LIMIT    = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pwm_duty_i,
  input  logic       meas_valid_i,
  output logic       meas_ready_o,
  input  logic [7:0] meas_speed_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  output logic       fan_fault_no,
  output logic       pwm_o
);

  localparam int DW = 8;

  cfg_t          cfg_w;
  logic [DW-1:0] limit_w;
  logic          take_w;
  logic          fail_w;
  logic          fault_w;
  logic          spin_w;
  logic          drive_w;

  assign meas_ready_o = 1'b1;
  assign take_w       = meas_valid_i && meas_ready_o;

  fan_guard_regs #(.DW(DW), .LIMIT_RESET(8'hFE)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_wr_i     (reg_wr_i),
    .reg_rd_i     (reg_rd_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .meas_take_i  (take_w),
    .meas_speed_i (meas_speed_i),
    .fail_evt_i   (fail_w),
    .cfg_o        (cfg_w),
    .limit_o      (limit_w),
    .irq_o        (irq_o)
  );

  fan_guard_judge #(.DW(DW), .FAIL_LIMIT(FAIL_LIMIT)) u_judge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take_w),
    .speed_i    (meas_speed_i),
    .limit_i    (limit_w),
    .fail_evt_o (fail_w),
    .fault_o    (fault_w)
  );

  fan_guard_spinup #(.TICKS_PER_SEC(TICKS_PER_SEC), .SPIN_SEC(SPIN_SEC)) u_spin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (fail_w),
    .tick_i (tick_i),
    .spin_o (spin_w)
  );

  assign drive_w      = spin_w | pwm_duty_i;
  assign pwm_o        = cfg_w.invert ? drive_w : ~drive_w;
  assign fan_fault_no = ~(fault_w & cfg_w.fault_en);

endmodule

// File: rtl/fan_guard_chk.sv
module fan_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       meas_valid_i,
  input logic       meas_ready_o,
  input logic [7:0] meas_speed_i,
  input logic [7:0] limit_w,
  input logic       reg_rd_i,
  input logic [1:0] reg_addr_i,
  input logic       irq_o,
  input logic       fan_fault_no,
  input logic       pwm_o,
  input logic       cfg_inv,
  input logic       cfg_fen
);

  // R4
  fail_sets_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_i && meas_speed_i > limit_w) |=> irq_o);

  // R4
  read_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd2 && !(meas_valid_i && meas_speed_i > limit_w)) |=> !irq_o);

  // R5
  fail_forces_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_i && meas_speed_i > limit_w) |=> (pwm_o == cfg_inv));

  // R7
  pass_releases_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_i && meas_speed_i <= limit_w) |=> fan_fault_no);

  // R2
  fault_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fan_fault_no |-> cfg_fen);

  // R10
  always_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_ready_o);

endmodule

bind fan_guard fan_guard_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .meas_valid_i (meas_valid_i),
  .meas_ready_o (meas_ready_o),
  .meas_speed_i (meas_speed_i),
  .limit_w      (limit_w),
  .reg_rd_i     (reg_rd_i),
  .reg_addr_i   (reg_addr_i),
  .irq_o        (irq_o),
  .fan_fault_no (fan_fault_no),
  .pwm_o        (pwm_o),
  .cfg_inv      (cfg_w.invert),
  .cfg_fen      (cfg_w.fault_en)
);

// File: tb/test_fan_guard.sv
module test_fan_guard;

  localparam int TPS = 4;
  localparam int SPS = 2;
  localparam int WIN = TPS * SPS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, duty = 1'b0, mv = 1'b0;
  logic [7:0] ms = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0;
  logic       ready, irq, fault_n, pwm;
  logic [7:0] rdata;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fan_guard #(.TICKS_PER_SEC(TPS), .SPIN_SEC(SPS), .FAIL_LIMIT(5)) i_fan_guard (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pwm_duty_i(duty),
    .meas_valid_i(mv), .meas_ready_o(ready), .meas_speed_i(ms),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .irq_o(irq), .fan_fault_no(fault_n), .pwm_o(pwm)
  );

  // behavioural reference state
  int m_inv, m_en, m_lim, m_stat, m_last, m_cnt, m_spin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_inv = 0; m_en = 1; m_lim = 254; m_stat = 0; m_last = 0; m_cnt = 0; m_spin = 0;
    end else begin
      int f;
      f = (mv && int'(ms) > m_lim) ? 1 : 0;
      if (f != 0) m_stat = 1;
      else if (rd && addr == 2) m_stat = 0;
      if (mv) begin
        m_last = int'(ms);
        m_cnt = (f != 0) ? ((m_cnt < 5) ? m_cnt + 1 : 5) : 0;
      end
      if (f != 0) m_spin = WIN;
      else if (tick && m_spin > 0) m_spin = m_spin - 1;
      if (wr && addr == 0) begin m_inv = int'(wd[3]); m_en = int'(wd[4]); end
      if (wr && addr == 1) m_lim = int'(wd);
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    case (addr)
      2'd0:    return (m_inv << 3) | (m_en << 4);
      2'd1:    return m_lim;
      2'd2:    return m_stat << 1;
      default: return m_last;
    endcase
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int drv;
      drv = (m_spin > 0 || duty) ? 1 : 0;
      check("R1/R5 pwm_o", int'(pwm), (m_inv != 0) ? drv : 1 - drv);
      check("R4 irq_o", int'(irq), m_stat);
      check("R6/R2 fan_fault_no", int'(fault_n), (m_cnt == 5 && m_en != 0) ? 0 : 1);
      check("R9 reg_rdata_o", int'(rdata), exp_rdata());
      check("R10 meas_ready_o", int'(ready), 1);
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic meas(input logic [7:0] s);
    mv = 1'b1; ms = s; cyc(); mv = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wd = d; cyc(); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a);
    rd = 1'b1; addr = a; cyc(); rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    addr = 2'd0; #1;
    check("R9 cfg reset", int'(rdata), 8'h10);
    check("R2 fault_n reset", int'(fault_n), 1);
    check("R4 irq reset", int'(irq), 0);
    addr = 2'd1; #1;
    check("R9 limit reset", int'(rdata), 8'hFE);
    cyc();

    // R3: stalled reading over default limit, equal passes
    meas(8'hFE);
    @(negedge clk); check("R3 equal passes", int'(irq), 0);
    cyc();
    meas(8'hFF);
    @(negedge clk); check("R3 over fails", int'(irq), 1);
    check("R5 drive forced (pin low, non-inverted)", int'(pwm), 0);
    cyc();
    rreg(2'd2);
    @(negedge clk); check("R4 read clears", int'(irq), 0);
    cyc();

    // R5 window length: WIN ticks
    tick = 1'b1;
    repeat (WIN - 1) cyc();
    @(negedge clk); check("R5 still forced", int'(pwm), 0);
    cyc();
    @(negedge clk); check("R5 window ended", int'(pwm), 1);
    tick = 1'b0; cyc();

    // R6: five consecutive failures (one already counted)
    repeat (3) meas(8'hFF);
    @(negedge clk); check("R6 four not fault", int'(fault_n), 1);
    cyc();
    meas(8'hFF);
    @(negedge clk); check("R6 fifth faults", int'(fault_n), 0);
    cyc();
    // R8: failures after fault still interrupt
    rreg(2'd2);
    meas(8'hFF);
    @(negedge clk); check("R8 irq after fault", int'(irq), 1);
    check("R6 saturated fault held", int'(fault_n), 0);
    cyc();
    // R2: disable the pin
    wreg(2'd0, 8'h00);
    @(negedge clk); check("R2 disabled pin high", int'(fault_n), 1);
    cyc();
    wreg(2'd0, 8'h18);
    @(negedge clk); check("R2 re-enabled", int'(fault_n), 0);
    check("R1 inverted full-on high", int'(pwm), 1);
    cyc();
    // R7 recovery
    meas(8'h10);
    @(negedge clk); check("R7 pass releases", int'(fault_n), 1);
    cyc();
    // R9 ignored writes
    wreg(2'd3, 8'h55);
    wreg(2'd2, 8'hFF);
    addr = 2'd3; #1;
    check("R9 speed unchanged", int'(rdata), 8'h10);
    addr = 2'd2; #1;
    check("R9 status not writable", int'(rdata), int'(irq) << 1);
    cyc();
    // R3 with limit 0x80
    wreg(2'd1, 8'h80);
    rreg(2'd2);
    meas(8'h80);
    @(negedge clk); check("R3 0x80 passes", int'(irq), 0);
    cyc();
    meas(8'h81);
    @(negedge clk); check("R3 0x81 fails", int'(irq), 1);
    cyc();
    // R4 read and fail together keeps flag
    rd = 1'b1; addr = 2'd2; mv = 1'b1; ms = 8'hF0; cyc();
    rd = 1'b0; mv = 1'b0;
    @(negedge clk); check("R4 set wins over clear", int'(irq), 1);
    cyc();

    // mixed random traffic, compared every clock by the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      tick = ($urandom_range(0, 3) == 0);
      duty = $urandom_range(0, 1) != 0;
      mv = (r < 25);
      ms = (r < 12) ? 8'(85 + $urandom_range(0, 100)) : 8'($urandom_range(0, 140));
      rd = (r >= 25 && r < 40);
      wr = (r >= 95);
      addr = 2'($urandom_range(0, 3));
      wd = (addr == 2'd1) ? 8'(100 + $urandom_range(0, 60)) : 8'($urandom);
      cyc();
    end
    mv = 1'b0; rd = 1'b0; wr = 1'b0; tick = 1'b0;
    cyc();
    finish_run();
  end

endmodule